// File: doc/BRIEF.md
# Sector Write Sequencer

This block moves one disk sector of 16-bit words from a byte-wide USB receive FIFO to a 16-bit parallel disk data port with no processor in the loop. A host pulses the start input once. The block raises busy and reads bytes from the FIFO, using the FIFO's data-available flag and an active-low read strobe. It pairs each two bytes into one word, high byte first, and commits the word to the drive with one active-low write strobe.

The drive side has a chip select, three register-address lines, a read strobe and a write strobe. Strobe widths and the data setup and hold times around the write strobe are parameters counted in clock cycles. The data-available flag is asynchronous to the block clock, so it passes through a two-flop synchronizer before the sequencer uses it. The block performs no error checking on either side.

Top module: `usb_sector_writer`

## Requirements
- R1: When `start_i` is high for one cycle while the block is idle, `busy_o` is high from the next cycle on. It stays high until the idle gap that follows the last word of the sector.
- R2: One transfer writes exactly WORDS words (default 256), which means exactly WORDS low pulses on `dsk_wr_n_o`. The block then returns to idle.
- R3: A byte read starts only when the synchronized data-available flag is high. `usb_avail_i` reaches the sequencer two clock edges after it is sampled. While the flag is low the block waits and keeps `usb_rd_n_o` high.
- R4: Each byte read drives `usb_rd_n_o` low for RD_LOW cycles. The byte on `usb_data_i` is captured at the clock edge that ends the last low cycle.
- R5: The first byte of each word goes to `dsk_data_o[15:8]` and the second byte goes to `dsk_data_o[7:0]`. The bus is stable from the start of the setup period through the end of the hold period.
- R6: After both bytes are latched, the data is held for WR_SETUP cycles. Then `dsk_wr_n_o` is low for WR_LOW cycles, followed by WR_HOLD hold cycles and then one gap cycle before the next word. The USB read strobe and the drive write strobe are never low together.
- R7: While busy, `dsk_cs_o` is 1, `dsk_addr_o` is 3'b000 (the data register) and `dsk_rd_n_o` is 1.
- R8: While idle and during reset, `dsk_cs_o` is 0, `busy_o` is 0, and `usb_rd_n_o`, `dsk_wr_n_o` and `dsk_rd_n_o` are 1.
- R9: A start pulse that arrives during a transfer has no effect. The word count and the output timing continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse from the host |
| busy_o | output | 1 | High while a sector transfer is in progress |
| usb_avail_i | input | 1 | FIFO data-available flag (asynchronous) |
| usb_data_i | input | 8 | FIFO read data |
| usb_rd_n_o | output | 1 | FIFO read strobe, active low |
| dsk_data_o | output | 16 | Disk data bus |
| dsk_cs_o | output | 1 | Drive chip select, active high |
| dsk_addr_o | output | 3 | Drive register address |
| dsk_rd_n_o | output | 1 | Drive read strobe, active low (held inactive) |
| dsk_wr_n_o | output | 1 | Drive write strobe, active low |

## Verification
The assertions assume that the FIFO keeps `usb_data_i` stable for the whole time the read strobe is low. They also assume that the data-available flag changes no faster than the synchronizer can follow. The bench therefore changes the FIFO byte only after the read strobe rises, and it drives the flag only at falling clock edges, using both a steady-high pattern and a pseudo-random pattern with stalls. Start pulses are one cycle wide, and one of them is deliberately placed in the middle of a transfer.

// File: rtl/usw_pkg.sv
package usw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT_HI, ST_RD_HI, ST_WAIT_LO, ST_RD_LO,
    ST_SETUP, ST_WRITE, ST_HOLD, ST_GAP, ST_GAP_END
  } usw_state_e;
endpackage

// File: rtl/usw_sync.sv
module usw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/usw_timer.sv
module usw_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)             cnt_d = val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/usw_word_cnt.sv
module usw_word_cnt #(
  parameter int WORDS = 256,
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = (cnt_q == CW'(WORDS-1)) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CW'(WORDS-1));

  // R2: a clear always leaves the count at zero
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/usb_sector_writer.sv
module usb_sector_writer #(
  parameter int WORDS    = 256,
  parameter int RD_LOW   = 2,
  parameter int WR_SETUP = 1,
  parameter int WR_LOW   = 2,
  parameter int WR_HOLD  = 1,
  localparam int MAXT = (RD_LOW > WR_LOW ? RD_LOW : WR_LOW) > (WR_SETUP > WR_HOLD ? WR_SETUP : WR_HOLD)
                        ? (RD_LOW > WR_LOW ? RD_LOW : WR_LOW) : (WR_SETUP > WR_HOLD ? WR_SETUP : WR_HOLD),
  localparam int TW = $clog2(MAXT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        busy_o,
  input  logic        usb_avail_i,
  input  logic [7:0]  usb_data_i,
  output logic        usb_rd_n_o,
  output logic [15:0] dsk_data_o,
  output logic        dsk_cs_o,
  output logic [2:0]  dsk_addr_o,
  output logic        dsk_rd_n_o,
  output logic        dsk_wr_n_o
);
  import usw_pkg::*;

  usw_state_e    state_q, state_d;
  logic          avail_s, tmr_done, tmr_load, last_word, cnt_clr, cnt_inc;
  logic          cap_hi, cap_lo;
  logic [TW-1:0] tmr_val;
  logic [7:0]    hi_q, lo_q;

  usw_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_i(usb_avail_i), .sync_o(avail_s));

  usw_timer #(.TW(TW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done));

  usw_word_cnt #(.WORDS(WORDS)) i_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc), .last_o(last_word));

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    cap_hi   = 1'b0;
    cap_lo   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_WAIT_HI;
        cnt_clr = 1'b1;
      end
      ST_WAIT_HI: if (avail_s) begin
        state_d  = ST_RD_HI;
        tmr_load = 1'b1;
        tmr_val  = TW'(RD_LOW - 1);
      end
      ST_RD_HI: if (tmr_done) begin
        cap_hi  = 1'b1;
        state_d = ST_WAIT_LO;
      end
      ST_WAIT_LO: if (avail_s) begin
        state_d  = ST_RD_LO;
        tmr_load = 1'b1;
        tmr_val  = TW'(RD_LOW - 1);
      end
      ST_RD_LO: if (tmr_done) begin
        cap_lo   = 1'b1;
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = TW'(WR_SETUP - 1);
      end
      ST_SETUP: if (tmr_done) begin
        state_d  = ST_WRITE;
        tmr_load = 1'b1;
        tmr_val  = TW'(WR_LOW - 1);
      end
      ST_WRITE: if (tmr_done) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = TW'(WR_HOLD - 1);
      end
      ST_HOLD: if (tmr_done) begin
        cnt_inc = 1'b1;
        state_d = last_word ? ST_GAP_END : ST_GAP;
      end
      ST_GAP:     state_d = ST_WAIT_HI;
      ST_GAP_END: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (cap_hi) hi_q <= usb_data_i;
      if (cap_lo) lo_q <= usb_data_i;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign usb_rd_n_o = !((state_q == ST_RD_HI) || (state_q == ST_RD_LO));
  assign dsk_wr_n_o = (state_q != ST_WRITE);
  assign dsk_rd_n_o = 1'b1;
  assign dsk_cs_o   = busy_o;
  assign dsk_addr_o = 3'b000;
  assign dsk_data_o = {hi_q, lo_q};

  // R1: a start pulse taken in idle raises busy on the next cycle
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> busy_o);
  // R3: no read strobe follows a cycle of waiting without data
  p_wait_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT_HI || state_q == ST_WAIT_LO) && !avail_s) |=> usb_rd_n_o);
  // R5: the data bus does not move while the write strobe is low
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsk_wr_n_o && $past(!dsk_wr_n_o)) |-> $stable(dsk_data_o));
  // R6: the FIFO read and the drive write never overlap
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!usb_rd_n_o && !dsk_wr_n_o));
  // R7: a write goes only to the selected data register
  p_write_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dsk_wr_n_o |-> (dsk_cs_o && dsk_addr_o == 3'b000 && dsk_rd_n_o));
  // R8: idle means drive deselected and all strobes released
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!dsk_cs_o && usb_rd_n_o && dsk_wr_n_o && dsk_rd_n_o));
  // R9: a start pulse during a transfer does not restart the count
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !cnt_clr);
endmodule

// File: tb/test_usb_sector_writer.sv
module test_usb_sector_writer;
  localparam int WORDS = 256, RD_LOW = 2, WR_SETUP = 1, WR_LOW = 2, WR_HOLD = 1;

  logic clk = 1'b0;
  logic rst_n, start, avail, rd_n, busy, cs, drd_n, wr_n;
  logic [7:0]  udata;
  logic [15:0] ddata;
  logic [2:0]  addr;

  always #5 clk = ~clk;

  usb_sector_writer #(.WORDS(WORDS), .RD_LOW(RD_LOW), .WR_SETUP(WR_SETUP),
                      .WR_LOW(WR_LOW), .WR_HOLD(WR_HOLD)) i_usb_sector_writer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
    .usb_avail_i(avail), .usb_data_i(udata), .usb_rd_n_o(rd_n),
    .dsk_data_o(ddata), .dsk_cs_o(cs), .dsk_addr_o(addr),
    .dsk_rd_n_o(drd_n), .dsk_wr_n_o(wr_n));

  int vectors = 0, errors = 0, cycles = 0;
  int byte_idx = 0, wr_pulses = 0, avail_mode = 0;
  int lfsr = 32'h1ACE;
  logic prev_rd_n = 1'b1, prev_wr_n = 1'b1;

  // behavioural reference: phase 0 idle, 1 wait hi, 2 read hi, 3 wait lo,
  // 4 read lo, 5 setup, 6 write, 7 hold, 8 gap
  int m_ph = 0, m_t = 0, m_words = 0;
  bit m_last = 0;
  logic m_s1 = 0, m_s2 = 0;
  logic [7:0] m_hi = 0, m_lo = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_words = 0; m_last = 0; m_s1 = 0; m_s2 = 0; m_hi = 0; m_lo = 0;
    end else begin
      case (m_ph)
        0: if (start) begin m_ph = 1; m_words = 0; end
        1: if (m_s2) begin m_ph = 2; m_t = RD_LOW; end
        2: begin m_t--; if (m_t == 0) begin m_hi = udata; m_ph = 3; end end
        3: if (m_s2) begin m_ph = 4; m_t = RD_LOW; end
        4: begin m_t--; if (m_t == 0) begin m_lo = udata; m_ph = 5; m_t = WR_SETUP; end end
        5: begin m_t--; if (m_t == 0) begin m_ph = 6; m_t = WR_LOW; end end
        6: begin m_t--; if (m_t == 0) begin m_ph = 7; m_t = WR_HOLD; end end
        7: begin m_t--; if (m_t == 0) begin m_words++; m_last = (m_words == WORDS); m_ph = 8; end end
        8: m_ph = m_last ? 0 : 1;
        default: m_ph = 0;
      endcase
      m_s2 = m_s1;
      m_s1 = avail;
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  function automatic logic [7:0] src_byte(input int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  // compare every cycle away from the active edge, then drive FIFO inputs
  always @(negedge clk) begin
    cycles++;
    chk("R1", "busy", {15'b0, busy}, {15'b0, m_ph != 0});
    chk("R4", "usb_rd_n", {15'b0, rd_n}, {15'b0, !(m_ph == 2 || m_ph == 4)});
    chk("R6", "wr_n", {15'b0, wr_n}, {15'b0, m_ph != 6});
    if (m_ph != 0) chk("R7", "cs/addr/rd", {12'b0, cs, addr}, 16'h0008);
    else           chk("R8", "idle cs/rd", {14'b0, cs, drd_n}, 16'h0001);
    if (m_ph >= 5 && m_ph <= 8) chk("R5", "data", ddata, {m_hi, m_lo});
    if (prev_wr_n && !wr_n) wr_pulses++;
    if (!prev_rd_n && rd_n) byte_idx++;
    prev_rd_n = rd_n;
    prev_wr_n = wr_n;
    udata = src_byte(byte_idx);
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    avail = (avail_mode == 0) ? 1'b1 : ((lfsr & 3) != 0);
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
  endtask

  task automatic run_sector(input bit interrupt);
    wr_pulses = 0;
    pulse_start();
    if (interrupt) begin
      repeat (300) @(negedge clk);
      pulse_start();  // R9: must be ignored
    end
    wait (busy == 1'b0);
    @(negedge clk); #2;
    chk("R2", "write pulses", 16'(wr_pulses), 16'(WORDS));
    chk("R2", "back to idle", {15'b0, busy}, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; avail = 1'b0; udata = 8'h00;
    repeat (3) @(negedge clk);
    #2;
    chk("R8", "reset wr/rd/cs", {13'b0, wr_n, rd_n, cs}, 16'h0006);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    avail_mode = 1;  // R3: stalls from the data-available flag
    run_sector(1'b0);
    avail_mode = 0;
    run_sector(1'b1);  // R9: start pulse mid-transfer
    avail_mode = 1;
    run_sector(1'b0);
    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule